// File: doc/BRIEF.md
# LPDDR5 Command-to-CA Frame Encoder

This block sits between a memory controller that issues single-phase DFI command strobes (chip select, row strobe, column strobe, write enable, plus bank and address fields) and the command pins of an LPDDR5 device. It translates each legacy strobe pattern into a frame of one to three CK cycles. Each frame cycle carries two 7-bit CA values, one for the rising half of CK and one for the falling half. While a frame is on the bus, the chip-select output is held high.

Read, write and mode-register read commands automatically get a one-cycle CAS frame in front of them, with the matching WCK-sync bit set. Any command that arrives while a frame is still being sent is dropped without trace. The DFI reset level is registered and forwarded to the memory reset pad. A configuration input chooses between masked-write and plain-write opcodes.

Top module: `lp5_ca_encoder`

## Requirements
- R1: When no frame cycle is being sent, ca_cs_o is 0 and both ca_rise_o and ca_fall_o are 0.
- R2: With dfi_cs_n=0, the strobes {ras_n,cas_n,we_n} decode as follows:
  - 011 is ACT, 010 is PRE, 001 is REF, 101 is RD, 100 is WR and 000 is MRW.
  - 110 is MRR when bank=1 and MPC when bank=0.
  - 111, any other bank on 110, and dfi_cs_n=1 produce no frame.
- R3: ACT is two cycles.
  - First cycle: rise={111,bank[3:0]}, fall={000,addr[17:14]}.
  - Second cycle: rise=addr[13:7], fall=addr[6:0].
- R4: PRE and REF are each a single cycle.
  - PRE: rise={110,bank[3:0]}. REF: rise={101,bank[3:0]}.
  - For both, fall={000000,addr[10]}, where addr[10]=1 selects all banks.
- R5: RD, WR and MRR are preceded by a CAS cycle with rise={011,0,rd_sync,wr_sync,0} and fall=0.
  - rd_sync=1 for RD and MRR; wr_sync=1 for WR.
- R6: After its CAS cycle, RD sends two cycles.
  - First: rise={010,bank[3:0]}, fall={addr[9:4],0}.
  - Second: rise={000,addr[3:0]}, fall=0.
- R7: After its CAS cycle, WR sends two cycles.
  - First: rise={001,bank[3:0]}, fall={addr[9:4],addr[10]}, where addr[10] is auto-precharge.
  - Second: rise={00,cfg_masked_write,addr[3:0]}, fall=0.
- R8: MRW is two cycles, with bank carrying the 7-bit register address and addr[7:0] the operand.
  - First: rise={100,bank[6:3]}, fall={bank[2:0],addr[7:4]}.
  - Second: rise={000,addr[3:0]}, fall=0.
- R9: MRR sends rise={0001,addr[6:4]}, fall={addr[3:0],000} after its CAS cycle, then one all-zero cycle with CS high.
  - MPC is a single cycle with rise=0000110, fall={000000,latch}.
  - latch is 0 for operand addr[7:0]=0x85 (ZQ start) and 1 for 0x86 (ZQ latch); other MPC operands produce no frame.
- R10: A command sampled while a frame still has cycles left to send is dropped. At most three consecutive CS-high cycles come from one frame.
- R11: The first frame cycle appears on the outputs in the cycle after the clock edge that samples the command. Later cycles follow on consecutive clocks.
- R12: mem_reset_n_o equals dfi_reset_n delayed by one clock, and is 0 while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CK-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dfi_cs_n | input | 1 | DFI chip select, active low |
| dfi_ras_n | input | 1 | DFI row strobe, active low |
| dfi_cas_n | input | 1 | DFI column strobe, active low |
| dfi_we_n | input | 1 | DFI write enable, active low |
| dfi_bank | input | 7 | Bank, or register address for MRW, or MRR/MPC selector |
| dfi_addr | input | 18 | Row, column, flag or operand field |
| dfi_reset_n | input | 1 | Memory reset level from the controller |
| cfg_masked_write | input | 1 | Selects the masked-write opcode for WR |
| ca_cs_o | output | 1 | Command-bus chip select |
| ca_rise_o | output | 7 | CA value for the rising half of CK |
| ca_fall_o | output | 7 | CA value for the falling half of CK |
| mem_reset_n_o | output | 1 | Registered reset to the memory pad |

## Verification
Every command type is sent once with distinctive bank and address values, so that swapped or misplaced field bits show up in the CA halves. Both all-bank flag values are sent for PRE and REF, and both masked-write settings for WR, which separates the one-bit variants. MPC is tried with the two ZQ operands and with an unsupported operand. Undefined strobe patterns check that no frame appears. Back-to-back sequences issue a new command in each cycle of a running frame, and then exactly at its end, which shows both dropping and the earliest accepted restart.

// File: rtl/lp5_ca_pkg.sv
package lp5_ca_pkg;
    localparam int CA_W      = 7;
    localparam int BANK_W    = 7;
    localparam int ADDR_W    = 18;
    localparam int MAX_WORDS = 3;
    localparam int LEN_W     = $clog2(MAX_WORDS + 1);
    localparam int WORD_W    = 2 * CA_W;
    localparam logic [7:0] ZQ_START_OP = 8'h85;
    localparam logic [7:0] ZQ_LATCH_OP = 8'h86;

    typedef logic [WORD_W-1:0] ca_word_t;   // {rise, fall}

    typedef enum logic [3:0] {
        K_NONE, K_ACT, K_PRE, K_REF, K_RD, K_WR, K_MRW, K_MRR, K_MPC
    } cmd_kind_t;

    typedef struct packed {
        logic [LEN_W-1:0]                len;
        ca_word_t [MAX_WORDS-1:0]        w;
    } frame_t;
endpackage

// File: rtl/lp5_cmd_decode.sv
module lp5_cmd_decode
    import lp5_ca_pkg::*;
(
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] bank,
    input  logic [7:0]        operand,
    output cmd_kind_t         kind,
    output logic              zq_latch
);
    always_comb begin
        kind     = K_NONE;
        zq_latch = 1'b0;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b011: kind = K_ACT;
                3'b010: kind = K_PRE;
                3'b001: kind = K_REF;
                3'b101: kind = K_RD;
                3'b100: kind = K_WR;
                3'b000: kind = K_MRW;
                3'b110: begin
                    if (bank == BANK_W'(1)) begin
                        kind = K_MRR;
                    end else if (bank == '0) begin
                        if (operand == ZQ_START_OP) begin
                            kind = K_MPC;
                        end else if (operand == ZQ_LATCH_OP) begin
                            kind     = K_MPC;
                            zq_latch = 1'b1;
                        end
                    end
                end
                default: kind = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/lp5_frame_build.sv
module lp5_frame_build
    import lp5_ca_pkg::*;
(
    input  cmd_kind_t         kind,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] addr,
    input  logic              masked,
    input  logic              zq_latch,
    output frame_t            frame
);
    function automatic ca_word_t cas_word(input logic rd_sync, input logic wr_sync);
        return {3'b011, 1'b0, rd_sync, wr_sync, 1'b0, 7'b0};
    endfunction

    always_comb begin
        frame = '0;
        unique case (kind)
            K_ACT: begin
                frame.len  = LEN_W'(2);
                frame.w[0] = {3'b111, bank[3:0], 3'b000, addr[17:14]};
                frame.w[1] = {addr[13:7], addr[6:0]};
            end
            K_PRE: begin
                frame.len  = LEN_W'(1);
                frame.w[0] = {3'b110, bank[3:0], 6'b0, addr[10]};
            end
            K_REF: begin
                frame.len  = LEN_W'(1);
                frame.w[0] = {3'b101, bank[3:0], 6'b0, addr[10]};
            end
            K_RD: begin
                frame.len  = LEN_W'(3);
                frame.w[0] = cas_word(1'b1, 1'b0);
                frame.w[1] = {3'b010, bank[3:0], addr[9:4], 1'b0};
                frame.w[2] = {3'b000, addr[3:0], 7'b0};
            end
            K_WR: begin
                frame.len  = LEN_W'(3);
                frame.w[0] = cas_word(1'b0, 1'b1);
                frame.w[1] = {3'b001, bank[3:0], addr[9:4], addr[10]};
                frame.w[2] = {2'b00, masked, addr[3:0], 7'b0};
            end
            K_MRW: begin
                frame.len  = LEN_W'(2);
                frame.w[0] = {3'b100, bank[6:3], bank[2:0], addr[7:4]};
                frame.w[1] = {3'b000, addr[3:0], 7'b0};
            end
            K_MRR: begin
                frame.len  = LEN_W'(3);
                frame.w[0] = cas_word(1'b1, 1'b0);
                frame.w[1] = {4'b0001, addr[6:4], addr[3:0], 3'b000};
                frame.w[2] = '0;
            end
            K_MPC: begin
                frame.len  = LEN_W'(1);
                frame.w[0] = {7'b0000110, 6'b0, zq_latch};
            end
            default: frame = '0;
        endcase
    end
endmodule

// File: rtl/lp5_ca_encoder.sv
module lp5_ca_encoder
    import lp5_ca_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dfi_cs_n,
    input  logic              dfi_ras_n,
    input  logic              dfi_cas_n,
    input  logic              dfi_we_n,
    input  logic [BANK_W-1:0] dfi_bank,
    input  logic [ADDR_W-1:0] dfi_addr,
    input  logic              dfi_reset_n,
    input  logic              cfg_masked_write,
    output logic              ca_cs_o,
    output logic [CA_W-1:0]   ca_rise_o,
    output logic [CA_W-1:0]   ca_fall_o,
    output logic              mem_reset_n_o
);
    typedef struct packed {
        ca_word_t                   out;
        logic                       cs;
        logic [LEN_W-1:0]           rem;
        ca_word_t [MAX_WORDS-2:0]   q;
        logic                       rst_pad;
    } seq_t;

    cmd_kind_t kind;
    logic      zq_latch;
    frame_t    frm;
    seq_t      s_d, s_q;

    lp5_cmd_decode u_decode (
        .cs_n     (dfi_cs_n),
        .ras_n    (dfi_ras_n),
        .cas_n    (dfi_cas_n),
        .we_n     (dfi_we_n),
        .bank     (dfi_bank),
        .operand  (dfi_addr[7:0]),
        .kind     (kind),
        .zq_latch (zq_latch)
    );

    lp5_frame_build u_build (
        .kind     (kind),
        .bank     (dfi_bank),
        .addr     (dfi_addr),
        .masked   (cfg_masked_write),
        .zq_latch (zq_latch),
        .frame    (frm)
    );

    always_comb begin
        s_d         = s_q;
        s_d.rst_pad = dfi_reset_n;
        if (s_q.rem != '0) begin
            // frame in flight: shift out next word, incoming command dropped
            s_d.out = s_q.q[0];
            for (int i = 0; i < MAX_WORDS - 2; i++) begin
                s_d.q[i] = s_q.q[i+1];
            end
            s_d.q[MAX_WORDS-2] = '0;
            s_d.rem = s_q.rem - LEN_W'(1);
            s_d.cs  = 1'b1;
        end else if (frm.len != '0) begin
            s_d.out = frm.w[0];
            for (int i = 0; i < MAX_WORDS - 1; i++) begin
                s_d.q[i] = frm.w[i+1];
            end
            s_d.rem = frm.len - LEN_W'(1);
            s_d.cs  = 1'b1;
        end else begin
            s_d.out = '0;
            s_d.q   = '0;
            s_d.rem = '0;
            s_d.cs  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ca_cs_o       = s_q.cs;
    assign ca_rise_o     = s_q.out[WORD_W-1:CA_W];
    assign ca_fall_o     = s_q.out[CA_W-1:0];
    assign mem_reset_n_o = s_q.rst_pad;
endmodule

// File: rtl/lp5_ca_encoder_chk.sv
module lp5_ca_encoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dfi_reset_n,
    input logic       ca_cs_o,
    input logic [6:0] ca_rise_o,
    input logic [6:0] ca_fall_o,
    input logic       mem_reset_n_o,
    input logic       busy
);
    logic       prev_busy;
    logic [2:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_busy <= 1'b0;
            run_q     <= '0;
        end else begin
            prev_busy <= busy;
            run_q     <= ca_cs_o ? ((run_q == 3'd7) ? run_q : run_q + 3'd1) : 3'd0;
        end
    end

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ca_cs_o |-> (ca_rise_o == 7'd0 && ca_fall_o == 7'd0));

    // R10
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ca_cs_o);

    // R10
    frame_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ca_cs_o && run_q >= 3'd2 && prev_busy) |-> !busy);

    // R12
    reset_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mem_reset_n_o == $past(dfi_reset_n)));

    // R5
    cas_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ca_cs_o && !prev_busy && ca_rise_o[6:4] == 3'b011) |=>
        (ca_cs_o && ca_rise_o[6:4] inside {3'b010, 3'b001, 3'b000}));

    // R3
    act_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ca_cs_o && !prev_busy && ca_rise_o[6:4] == 3'b111) |-> busy);

    // R4
    pre_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ca_cs_o && !prev_busy && ca_rise_o[6:5] == 2'b11 && ca_rise_o[4] == 1'b0) |-> !busy);
endmodule

bind lp5_ca_encoder lp5_ca_encoder_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dfi_reset_n   (dfi_reset_n),
    .ca_cs_o       (ca_cs_o),
    .ca_rise_o     (ca_rise_o),
    .ca_fall_o     (ca_fall_o),
    .mem_reset_n_o (mem_reset_n_o),
    .busy          (s_q.rem != '0)
);

// File: tb/lp5_ca_encoder_bench.sv
module lp5_ca_encoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [6:0]  bank = '0;
    logic [17:0] addr = '0;
    logic        dfi_rst = 1'b0;
    logic        masked = 1'b0;
    logic        ca_cs;
    logic [6:0]  ca_rise, ca_fall;
    logic        mem_rst;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lp5_ca_encoder u_lp5_ca_encoder (
        .clk(clk), .rst_n(rst_n),
        .dfi_cs_n(cs_n), .dfi_ras_n(ras_n), .dfi_cas_n(cas_n), .dfi_we_n(we_n),
        .dfi_bank(bank), .dfi_addr(addr), .dfi_reset_n(dfi_rst),
        .cfg_masked_write(masked),
        .ca_cs_o(ca_cs), .ca_rise_o(ca_rise), .ca_fall_o(ca_fall),
        .mem_reset_n_o(mem_rst)
    );

    // independent model of the frame table in the requirements
    function automatic int ref_frame(input logic [3:0] s, input logic [6:0] b,
                                     input logic [17:0] a, input logic m,
                                     output logic [2:0][13:0] w);
        int n = 0;
        w = '0;
        if (!s[3]) begin
            case (s[2:0])
                3'b011: begin w[0] = {3'b111, b[3:0], 3'b000, a[17:14]}; w[1] = {a[13:7], a[6:0]}; n = 2; end
                3'b010: begin w[0] = {3'b110, b[3:0], 6'b0, a[10]}; n = 1; end
                3'b001: begin w[0] = {3'b101, b[3:0], 6'b0, a[10]}; n = 1; end
                3'b101: begin w[0] = {7'b0110100, 7'b0}; w[1] = {3'b010, b[3:0], a[9:4], 1'b0};
                              w[2] = {3'b000, a[3:0], 7'b0}; n = 3; end
                3'b100: begin w[0] = {7'b0110010, 7'b0}; w[1] = {3'b001, b[3:0], a[9:4], a[10]};
                              w[2] = {2'b00, m, a[3:0], 7'b0}; n = 3; end
                3'b000: begin w[0] = {3'b100, b[6:3], b[2:0], a[7:4]}; w[1] = {3'b000, a[3:0], 7'b0}; n = 2; end
                3'b110: begin
                    if (b == 7'd1) begin
                        w[0] = {7'b0110100, 7'b0}; w[1] = {4'b0001, a[6:4], a[3:0], 3'b000}; n = 3;
                    end else if (b == 7'd0 && a[7:0] == 8'h85) begin
                        w[0] = {7'b0000110, 7'b0000000}; n = 1;
                    end else if (b == 7'd0 && a[7:0] == 8'h86) begin
                        w[0] = {7'b0000110, 7'b0000001}; n = 1;
                    end
                end
                default: n = 0;
            endcase
        end
        return n;
    endfunction

    task automatic put(input logic [3:0] s, input logic [6:0] b, input logic [17:0] a);
        {cs_n, ras_n, cas_n, we_n} = s;
        bank = b;
        addr = a;
    endtask

    task automatic idle();
        put(4'b1111, 7'd0, 18'd0);
    endtask

    task automatic step_chk(input string tag, input logic ecs, input logic [13:0] ew);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (ca_cs !== ecs || {ca_rise, ca_fall} !== ew) begin
            fails++;
            $display("FAIL %s: got cs=%b ca=%b_%b expected cs=%b ca=%b_%b",
                     tag, ca_cs, ca_rise, ca_fall, ecs, ew[13:7], ew[6:0]);
        end
    endtask

    // one command, then every frame cycle, then one idle cycle
    task automatic send_and_check(input string tag, input logic [3:0] s,
                                  input logic [6:0] b, input logic [17:0] a);
        logic [2:0][13:0] w;
        int n;
        n = ref_frame(s, b, a, masked, w);
        put(s, b, a);
        for (int i = 0; i < n; i++) begin
            step_chk(i == 0 ? {"R11 ", tag} : tag, 1'b1, w[i]);
            if (i == 0) idle();
        end
        if (n == 0) begin
            step_chk({"R1 ", tag}, 1'b0, 14'd0);
            idle();
        end
        step_chk({"R1 after ", tag}, 1'b0, 14'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        checks++;
        if (ca_cs !== 1'b0 || {ca_rise, ca_fall} !== 14'd0 || mem_rst !== 1'b0) begin
            fails++;
            $display("FAIL R12 reset state: cs=%b ca=%h rst=%b expected 0/0/0", ca_cs, {ca_rise, ca_fall}, mem_rst);
        end
        dfi_rst = 1'b1;
        rst_n = 1'b1;
        step_chk("R1 idle after reset", 1'b0, 14'd0);
        checks++;
        if (mem_rst !== 1'b1) begin fails++; $display("FAIL R12 forward high: got %b expected 1", mem_rst); end
        dfi_rst = 1'b0;
        checks++;
        if (mem_rst !== 1'b1) begin fails++; $display("FAIL R12 not yet low: got %b expected 1", mem_rst); end
        @(posedge clk); @(negedge clk);
        checks++;
        if (mem_rst !== 1'b0) begin fails++; $display("FAIL R12 forward low: got %b expected 0", mem_rst); end
        dfi_rst = 1'b1;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic t_row_cmds();
        send_and_check("R3 act", 4'b0011, 7'd2, 18'b111110000111100001);
        send_and_check("R4 pre bank", 4'b0010, 7'd7, 18'd0);
        send_and_check("R4 pre all", 4'b0010, 7'd5, 18'h00400);
        send_and_check("R4 ref all", 4'b0001, 7'd9, 18'h00400);
        send_and_check("R4 ref bank", 4'b0001, 7'd3, 18'd0);
    endtask

    task automatic t_col_cmds();
        send_and_check("R5 R6 read", 4'b0101, 7'd15, 18'b1101010000);
        masked = 1'b1;
        send_and_check("R5 R7 write ap masked", 4'b0100, 7'd10, 18'h0057B);
        masked = 1'b0;
        send_and_check("R7 write plain", 4'b0100, 7'd6, 18'h0012D);
    endtask

    task automatic t_mode_cmds();
        send_and_check("R8 mrw", 4'b0000, 7'b1010011, 18'b10101010);
        send_and_check("R9 mrr", 4'b0110, 7'd1, 18'b1101101);
        send_and_check("R9 zq start", 4'b0110, 7'd0, 18'h00085);
        send_and_check("R9 zq latch", 4'b0110, 7'd0, 18'h00086);
        send_and_check("R9 mpc other", 4'b0110, 7'd0, 18'h00042);
        send_and_check("R2 bank2 on 110", 4'b0110, 7'd2, 18'h00085);
        send_and_check("R2 pattern 111", 4'b0111, 7'd4, 18'h3FFFF);
        send_and_check("R2 cs high", 4'b1011, 7'd4, 18'h3FFFF);
    endtask

    task automatic t_overlap();
        logic [2:0][13:0] wr, wa, wp;
        int n;
        n = ref_frame(4'b0101, 7'd4, 18'h002A5, 1'b0, wr);
        n = ref_frame(4'b0011, 7'd1, 18'h15555, 1'b0, wa);
        n = ref_frame(4'b0010, 7'd8, 18'h00400, 1'b0, wp);
        put(4'b0101, 7'd4, 18'h002A5);
        step_chk("R11 overlap rd cas", 1'b1, wr[0]);
        put(4'b0011, 7'd3, 18'h0F0F0);
        step_chk("R10 rd w1 act dropped", 1'b1, wr[1]);
        put(4'b0010, 7'd3, 18'h00400);
        step_chk("R10 rd w2 pre dropped", 1'b1, wr[2]);
        put(4'b0011, 7'd1, 18'h15555);
        step_chk("R10 act right after", 1'b1, wa[0]);
        put(4'b0011, 7'd6, 18'h3FFFF);
        step_chk("R10 act w1 second act dropped", 1'b1, wa[1]);
        put(4'b0010, 7'd8, 18'h00400);
        step_chk("R10 pre after act", 1'b1, wp[0]);
        idle();
        step_chk("R1 overlap end", 1'b0, 14'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_row_cmds();
        t_col_cmds();
        t_mode_cmds();
        t_overlap();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule